// File: doc/BRIEF.md
# Delta-Sigma Converter Result Reader

This block is the host end of a three-wire link to a serial delta-sigma converter. A one-cycle request on `start_i` pulls chip select low. The block then watches the serial data line until the converter drives it low, which means a conversion has finished. It then produces 32 serial clock pulses and collects one bit on each rising edge, most significant bit first. The serial clock half-period is set by a divider parameter.

When the last pulse has ended, the block releases chip select and decodes the 32-bit frame. The sign bit and the 24 magnitude bits become a 25-bit two's-complement value. The two clamp codes raise an over-range flag or an under-range flag, and a 1 in the always-zero position raises a framing error. All of these appear at the outputs together with a one-cycle valid strobe. If the converter never signals completion, a programmable timeout ends the wait, releases chip select and pulses a timeout flag.

The controller is a three-state machine:
- `ST_IDLE`: chip select is high and the serial clock is low.
- `ST_POLL`: chip select is low and the block waits for the data line to go low.
- `ST_SHIFT`: chip select is low and the block clocks in the frame.

The transitions are:
- `ST_IDLE` to `ST_POLL` on a start request.
- `ST_POLL` to `ST_SHIFT` when the data line is seen low.
- `ST_POLL` to `ST_IDLE` when the timeout expires.
- `ST_SHIFT` to `ST_IDLE` on the falling edge of the 32nd pulse.

Top module: `dsadc_frame_reader`

## Requirements
- R1: After reset, `csn_o` is 1, `sck_o` is 0, `valid_o` and `timeout_o` are 0, and `result_o`, `over_o`, `under_o` and `frame_err_o` are all 0.
- R2: A start request in the idle state drives `csn_o` to 0. While `sdi_i` stays high, `sck_o` stays low.
- R3: Once `sdi_i` is seen low, exactly 32 serial clock pulses follow. Each high phase and each low phase lasts `CLK_DIV` system clocks, and `sck_o` is low whenever `csn_o` is high.
- R4: `sdi_i` is captured on the system clock edge at which `sck_o` rises. The first captured bit is frame bit 31 and the last is frame bit 0.
- R5: After the falling edge of the 32nd pulse, `csn_o` returns to 1 and `valid_o` pulses for exactly one cycle. In that same cycle the count of pulses since chip select fell is 32.
- R6: `result_o` equals the inverse of frame bit 29 followed by frame bits 28 down to 5. Zero input (bit 29 = 1 with zero magnitude) gives 0, and bit 29 = 0 with all magnitude bits 1 gives all ones. Frame bits 4 to 0 have no effect.
- R7: `over_o` is 1 exactly when frame bits 29 and 28 are both 1. `under_o` is 1 exactly when both are 0. The two are never 1 together.
- R8: `frame_err_o` equals frame bit 30, which a correct frame always holds at 0.
- R9: If `sdi_i` is still high after `TIMEOUT_CYC` cycles in the polling state, `timeout_o` pulses for one cycle and `csn_o` returns to 1. No serial clock pulse is issued, the result outputs keep their previous values, and `valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to read one result |
| sdi_i | input | 1 | Serial data from the converter |
| csn_o | output | 1 | Active-low chip select |
| sck_o | output | 1 | Serial clock to the converter |
| result_o | output | 25 | Two's-complement result |
| over_o | output | 1 | Input at or above positive full scale |
| under_o | output | 1 | Input below negative full scale |
| frame_err_o | output | 1 | Always-zero frame bit read as 1 |
| valid_o | output | 1 | One-cycle strobe with a new result |
| timeout_o | output | 1 | One-cycle strobe when the wait timed out |

## Verification
The result decode is probed with zero and minus one LSB. A design that passes the sign bit through unchanged would turn zero into the most negative value.

The exact positive full-scale code and the code just below negative full scale check the range flags. A flag decode that looks at the wrong bit would raise an over-range flag one LSB early, or miss the under-range clamp.

Frames with busy low-order bits and a set always-zero bit show whether decoding stays confined to the documented field positions. A mixed-bit pattern catches sampling on the wrong serial clock edge, because every captured bit would then move by one place.

The timeout is exercised both by a wait that expires and by a completion that arrives just before expiry. A timer that is off by one, or that overwrites the held result when it expires, shows up in these two tests.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    localparam int FRAME_BITS = 32;
    localparam int RES_BITS   = 25;

    // Bit positions the decoder relies on
    localparam int POS_DUMMY  = 30;
    localparam int POS_SIGN   = 29;
    localparam int POS_MAG_HI = 28;
    localparam int POS_MAG_LO = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_POLL  = 2'd1,
        ST_SHIFT = 2'd2
    } rd_state_t;

    typedef struct packed {
        logic [RES_BITS-1:0] value;
        logic                over;
        logic                under;
        logic                ferr;
    } rd_result_t;

endpackage

// File: rtl/dsadc_sck_gen.sv
module dsadc_sck_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] phase_cnt;
    logic          tick;

    assign tick = run && (phase_cnt == CW'(HALF_DIV - 1));
    assign rise = tick && !sck;
    assign fall = tick && sck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_cnt <= '0;
            sck       <= 1'b0;
        end else if (!run) begin
            phase_cnt <= '0;
            sck       <= 1'b0;
        end else if (tick) begin
            phase_cnt <= '0;
            sck       <= ~sck;
        end else begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dsadc_shifter.sv
module dsadc_shifter #(
    parameter int WIDTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         shift_en,
    input  logic                         din,
    output logic [WIDTH-1:0]             data,
    output logic [$clog2(WIDTH+1)-1:0]   count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (shift_en) begin
            data  <= {data[WIDTH-2:0], din};
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/dsadc_decode.sv
module dsadc_decode
    import dsadc_pkg::*;
(
    input  logic [FRAME_BITS-1:0] frame,
    output rd_result_t            res
);
    logic sign_bit;
    logic top_mag;

    assign sign_bit = frame[POS_SIGN];
    assign top_mag  = frame[POS_MAG_HI];

    always_comb begin
        // Offset form to two's complement: invert the sign position
        res.value = {~sign_bit, frame[POS_MAG_HI:POS_MAG_LO]};
        res.over  = sign_bit & top_mag;
        res.under = ~sign_bit & ~top_mag;
        res.ferr  = frame[POS_DUMMY];
    end
endmodule

// File: rtl/dsadc_frame_reader.sv
module dsadc_frame_reader
    import dsadc_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                sdi_i,
    output logic                csn_o,
    output logic                sck_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                over_o,
    output logic                under_o,
    output logic                frame_err_o,
    output logic                valid_o,
    output logic                timeout_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam int CW = $clog2(FRAME_BITS + 1);

    rd_state_t             state, state_nxt;
    logic [TW-1:0]         wait_cnt;
    logic                  wait_expired;
    logic                  sck_rise, sck_fall;
    logic [FRAME_BITS-1:0] frame;
    logic [CW-1:0]         bits_in;
    logic                  frame_done;
    rd_result_t            decoded;

    dsadc_sck_gen #(.HALF_DIV(CLK_DIV)) u_sck (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state == ST_SHIFT),
        .sck  (sck_o),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    dsadc_shifter #(.WIDTH(FRAME_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state != ST_SHIFT),
        .shift_en(sck_rise),
        .din     (sdi_i),
        .data    (frame),
        .count   (bits_in)
    );

    dsadc_decode u_dec (
        .frame(frame),
        .res  (decoded)
    );

    assign wait_expired = (wait_cnt == TW'(TIMEOUT_CYC - 1));
    assign frame_done   = (state == ST_SHIFT) && sck_fall
                          && (bits_in == CW'(FRAME_BITS));
    assign csn_o        = (state == ST_IDLE);

    // Wait timer, runs only while polling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wait_cnt <= '0;
        else if (state != ST_POLL)
            wait_cnt <= '0;
        else
            wait_cnt <= wait_cnt + 1'b1;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (start_i) state_nxt = ST_POLL;
            ST_POLL: begin
                if (!sdi_i)
                    state_nxt = ST_SHIFT;
                else if (wait_expired)
                    state_nxt = ST_IDLE;
            end
            ST_SHIFT: if (frame_done) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o     <= 1'b0;
            timeout_o   <= 1'b0;
            result_o    <= '0;
            over_o      <= 1'b0;
            under_o     <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            valid_o   <= frame_done;
            timeout_o <= (state == ST_POLL) && sdi_i && wait_expired;
            if (frame_done) begin
                result_o    <= decoded.value;
                over_o      <= decoded.over;
                under_o     <= decoded.under;
                frame_err_o <= decoded.ferr;
            end
        end
    end
endmodule

// File: rtl/dsadc_frame_reader_chk.sv
module dsadc_frame_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic csn_o,
    input logic sck_o,
    input logic over_o,
    input logic under_o,
    input logic valid_o,
    input logic timeout_o
);
    logic       sck_q;
    logic [7:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sck_q    <= sck_o;
            rise_cnt <= csn_o ? 8'd0 : rise_cnt + {7'd0, (sck_o && !sck_q)};
        end
    end

    a_r3_sck_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        csn_o |-> !sck_o);
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    a_r5_valid_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> csn_o);
    a_r5_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (rise_cnt == 8'd32));
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(over_o && under_o));
    a_r9_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (csn_o && rise_cnt == 8'd0 && !valid_o));
    a_r9_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);
endmodule

bind dsadc_frame_reader dsadc_frame_reader_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn_o    (csn_o),
    .sck_o    (sck_o),
    .over_o   (over_o),
    .under_o  (under_o),
    .valid_o  (valid_o),
    .timeout_o(timeout_o)
);

// File: tb/dsadc_frame_reader_bench.sv
module dsadc_frame_reader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int TMO        = 200;
    localparam int NVEC       = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        sdi_i;
    logic        csn_o, sck_o, over_o, under_o, frame_err_o, valid_o, timeout_o;
    logic [24:0] result_o;

    int tests = 0;
    int fails = 0;

    // Device model state
    logic [31:0] dev_frame = 32'hFFFF_FFFF;
    logic        dev_busy = 1'b1;
    int          dev_idx = 31;
    int          rise_cnt = 0;
    time         t_last = 0;
    time         per_meas = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsadc_frame_reader #(.CLK_DIV(DIV), .TIMEOUT_CYC(TMO)) u_dsadc_frame_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sdi_i(sdi_i),
        .csn_o(csn_o), .sck_o(sck_o), .result_o(result_o), .over_o(over_o),
        .under_o(under_o), .frame_err_o(frame_err_o), .valid_o(valid_o),
        .timeout_o(timeout_o)
    );

    assign sdi_i = dev_busy ? 1'b1 : dev_frame[dev_idx];

    always @(negedge sck_o) if (dev_idx > 0) dev_idx = dev_idx - 1;

    always @(posedge sck_o) begin
        if (rise_cnt == 1) per_meas = $time - t_last;
        t_last   = $time;
        rise_cnt = rise_cnt + 1;
    end

    // {frame, expected result, over, under, frame error}
    localparam logic [59:0] VEC [NVEC] = '{
        {32'h2000_0000, 25'h000_0000, 1'b0, 1'b0, 1'b0},  // zero
        {32'h1FFF_FFE0, 25'h1FF_FFFF, 1'b0, 1'b0, 1'b0},  // minus one LSB
        {32'h3000_0000, 25'h080_0000, 1'b1, 1'b0, 1'b0},  // at +FS
        {32'h2FFF_FFE0, 25'h07F_FFFF, 1'b0, 1'b0, 1'b0},  // +FS - 1
        {32'h2800_0000, 25'h040_0000, 1'b0, 1'b0, 1'b0},  // quarter scale
        {32'h1000_0000, 25'h180_0000, 1'b0, 1'b0, 1'b0},  // at -FS
        {32'h0FFF_FFE0, 25'h17F_FFFF, 1'b0, 1'b1, 1'b0},  // below -FS
        {32'h6000_0000, 25'h000_0000, 1'b0, 1'b0, 1'b1},  // dummy bit set
        {32'h2000_001F, 25'h000_0000, 1'b0, 1'b0, 1'b0},  // low bits busy
        {32'h1800_0000, 25'h1C0_0000, 1'b0, 1'b0, 1'b0},  // minus quarter
        {32'h2ABC_DEF0, 25'h055_E6F7, 1'b0, 1'b0, 1'b0}   // mixed bits
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [31:0] frame, input int delay,
                             output int got_valid);
        got_valid = 0;
        dev_busy  = 1'b1;
        dev_frame = frame;
        dev_idx   = 31;
        rise_cnt  = 0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (delay) @(negedge clk);
        // R2: selected, no clock while waiting
        chk("R2 csn low while polling", {63'd0, csn_o}, 64'd0);
        chk("R2 no sck before eoc", rise_cnt, 0);
        dev_busy = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (valid_o) begin
                got_valid = 1;
                break;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        int          gv;
        logic [24:0] last_res;
        int          cyc;
        int          seen;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 csn", {63'd0, csn_o}, 64'd1);
        chk("R1 sck", {63'd0, sck_o}, 64'd0);
        chk("R1 strobes", {62'd0, valid_o, timeout_o}, 64'd0);
        chk("R1 result", {36'd0, result_o, over_o, under_o, frame_err_o}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] fr;
            logic [27:0] ex;
            fr = VEC[i][59:28];
            ex = VEC[i][27:0];
            run_frame(fr, 1 + 3 * i, gv);
            chk("R5 valid seen", gv, 1);
            chk("R5 pulse count", rise_cnt, 32);
            chk("R5 csn released", {63'd0, csn_o}, 64'd1);
            chk("R6 R4 result", {39'd0, result_o}, {39'd0, ex[27:3]});
            chk("R7 range flags", {62'd0, over_o, under_o}, {62'd0, ex[2:1]});
            chk("R8 frame error", {63'd0, frame_err_o}, {63'd0, ex[0]});
            if (i == 0)
                chk("R3 sck period", per_meas, 2 * DIV * CLK_PERIOD);
            @(negedge clk);
            chk("R5 valid one cycle", {63'd0, valid_o}, 64'd0);
            chk("R3 sck idle low", {63'd0, sck_o}, 64'd0);
        end

        // R9: eoc arrives shortly before the timeout
        run_frame(32'h2000_0020, TMO - 5, gv);
        chk("R9 late eoc still read", gv, 1);
        chk("R9 late eoc result", {39'd0, result_o}, 64'd1);
        last_res = result_o;

        // R9: eoc never arrives
        dev_busy = 1'b1;
        rise_cnt = 0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        cyc  = 0;
        seen = 0;
        for (int k = 1; k < TMO + 50; k++) begin
            @(negedge clk);
            if (valid_o) seen = 1;
            if (timeout_o) begin
                cyc = k;
                break;
            end
        end
        chk("R9 timeout latency", cyc, TMO);
        chk("R9 csn released", {63'd0, csn_o}, 64'd1);
        chk("R9 no sck", rise_cnt, 0);
        chk("R9 no valid", seen, 0);
        chk("R9 result held", {39'd0, result_o}, {39'd0, last_res});
        @(negedge clk);
        chk("R9 timeout one cycle", {63'd0, timeout_o}, 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule